// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This block keeps the time of day and the calendar date in seven packed-BCD registers (seconds, minutes, hours, day of month, month, weekday and two-digit year). It advances once per second, where a second is a fixed number of pulses on a tick input (`SUBDIV`, default 1, so one pulse per second). Each field carries into the next: seconds into minutes, minutes into hours, the midnight hour crossing into the day and weekday, the month end into the month, and December into the year.

A host interface, outside this block, loads any field through a one-cycle write strobe with a field select. All seven fields are always visible on output ports. The hours register holds its own mode bit, so software chooses either a 00–23 count or a 01–12 count with an AM/PM flag. A halt flag in the seconds register freezes all counting while the stored time stays readable and writable.

Top module: `rtc_bcd_core`

## Requirements
- R1: Field select codes are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 weekday, 6 year. A write loads the field at the next clock edge, with bits forced to zero as follows: minutes bit 7, hours bit 6, day-of-month bits 7:6, month bits 7:5, weekday bits 7:3. Select code 7 changes nothing.
- R2: Seconds (bits 6:0, BCD) advance by one after `SUBDIV` accepted ticks and go from 59 to 00 with a carry into minutes.
- R3: While seconds bit 7 (halt) is 1, ticks are ignored and no field or sub-second count changes.
- R4: Minutes go from 59 to 00 with a carry into hours.
- R5: With hours bit 7 = 0 (24-hour mode, tens digit in bits 5:4), hours run 00 to 23, and 23 to 00 starts a new day.
- R6: With hours bit 7 = 1 (12-hour mode, bit 5 = PM, hours in bits 4:0), 11 goes to 12 with the PM flag toggled, 12 goes to 01 with the flag kept, and 11 PM to 12 AM starts a new day.
- R7: A new day advances the weekday by one, with 07 wrapping to 01, and advances the day of month.
- R8: The day of month wraps to 01 after its last day: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for 04, 06, 09 and 11, and for 02 it is 29 when the year is a multiple of 4 and 28 otherwise. The wrap advances the month.
- R9: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R10: A tick in the same cycle as a write (select 0 to 6) is discarded: only the written field changes.
- R11: A write to seconds clears the sub-second tick count, so the next second falls exactly `SUBDIV` accepted ticks after the write.
- R12: After reset: seconds 00 with halt clear, minutes 00, hours 00 in 24-hour mode, day 01, month 01, weekday 01, year 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sub-second tick pulse |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 8 | Halt flag and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Mode bit, PM flag or tens, hours |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| wday_o | output | 8 | Weekday |
| year_o | output | 8 | Year |

## Verification
A host write and a completing tick can fall in the same cycle, and the write must win while the whole carry chain stays still. The bench brings the sub-second count to its last step and then asserts the tick together with a minutes write, and again after a seconds write, which must also restart the count. A behavioural model with integer fields, compared on every clock, judges whether seconds held and exactly one extra second arrives `SUBDIV` ticks later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } fld_e;

  // Add one to a two-digit packed BCD value (no range wrap here).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // A two-digit BCD year is a multiple of four when the tens digit is even
  // and the units are 0/4/8, or the tens digit is odd and the units are 2/6.
  function automatic logic bcd_mult4(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  // Last day of a BCD month.
  function automatic logic [7:0] month_end(input logic [7:0] m, input logic leap);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate
  import rtc_pkg::*;
#(
  parameter int SUBDIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic halt_i,
  input  logic any_wr_i,
  input  logic sec_wr_i,
  output logic adv_o
);
  localparam int CW = (SUBDIV > 1) ? $clog2(SUBDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUBDIV - 1);

  logic [CW-1:0] cnt_q;
  logic          take;

  assign take  = tick_i && !halt_i && !any_wr_i;
  assign adv_o = take && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sec_wr_i) cnt_q <= '0;
    else if (take)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_HALT_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !any_wr_i) |=> $stable(cnt_q)); // R3

  AST_SECWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_i |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       halt_o,
  output logic       sec_wr_o,
  output logic       day_carry_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] sec_nx, min_nx, hour_nx;
  logic       sec_wrap, min_wrap, mode12, pm;

  assign mode12 = hour_q[7];
  assign pm     = hour_q[5];

  assign sec_wrap    = adv_i && (sec_q[6:0] == 7'h59);
  assign min_wrap    = sec_wrap && (min_q == 8'h59);
  assign day_carry_o = min_wrap &&
                       (mode12 ? (pm && hour_q[4:0] == 5'h11) : (hour_q[5:0] == 6'h23));

  always_comb begin
    sec_nx = sec_wrap ? {sec_q[7], 7'h00}
                      : ((bcd_inc(sec_q & 8'h7F) & 8'h7F) | {sec_q[7], 7'h00});
    min_nx = (min_q == 8'h59) ? 8'h00 : (bcd_inc(min_q) & 8'h7F);
    if (!mode12) begin
      hour_nx = (hour_q[5:0] == 6'h23) ? 8'h00 : (bcd_inc(hour_q & 8'h3F) & 8'h3F);
    end else if (hour_q[4:0] == 5'h12) begin
      hour_nx = {1'b1, 1'b0, pm, 5'h01};
    end else if (hour_q[4:0] == 5'h11) begin
      hour_nx = {1'b1, 1'b0, ~pm, 5'h12};
    end else begin
      hour_nx = (bcd_inc(hour_q & 8'h1F) & 8'h1F) | {1'b1, 1'b0, pm, 5'h00};
    end
  end

  assign sec_wr_o = wr_en_i && (wr_sel_i == FLD_SEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (sec_wr_o) sec_q <= wr_data_i;
      else if (adv_i) sec_q <= sec_nx;

      if (wr_en_i && wr_sel_i == FLD_MIN) min_q <= wr_data_i & 8'h7F;
      else if (sec_wrap) min_q <= min_nx;

      if (wr_en_i && wr_sel_i == FLD_HOUR) hour_q <= wr_data_i & 8'hBF;
      else if (min_wrap) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign halt_o = sec_q[7];

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_o[6:0] == 7'h00)); // R2

  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    min_wrap |=> (min_o == 8'h00)); // R4

  AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !mode12 && hour_q == 8'h23) |=> (hour_o == 8'h00)); // R5

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && mode12 && hour_q[4:0] == 5'h11) |=> (hour_o[5] != $past(hour_o[5]))); // R6

  AST_NOON_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && mode12 && hour_q[4:0] == 5'h12) |=> $stable(hour_o[5])); // R6

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  logic [7:0] date_q, month_q, wday_q, year_q;
  logic [7:0] last_day;
  logic       leap, month_carry, year_carry;

  assign leap        = bcd_mult4(year_q);
  assign last_day    = month_end(month_q, leap);
  assign month_carry = day_carry_i && (date_q == last_day);
  assign year_carry  = month_carry && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      wday_q  <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_en_i && wr_sel_i == FLD_DATE) date_q <= wr_data_i & 8'h3F;
      else if (day_carry_i) date_q <= month_carry ? 8'h01 : bcd_inc(date_q);

      if (wr_en_i && wr_sel_i == FLD_WDAY) wday_q <= wr_data_i & 8'h07;
      else if (day_carry_i) wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;

      if (wr_en_i && wr_sel_i == FLD_MONTH) month_q <= wr_data_i & 8'h1F;
      else if (month_carry) month_q <= year_carry ? 8'h01 : bcd_inc(month_q);

      if (wr_en_i && wr_sel_i == FLD_YEAR) year_q <= wr_data_i;
      else if (year_carry) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign date_o  = date_q;
  assign month_o = month_q;
  assign wday_o  = wday_q;
  assign year_o  = year_q;

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && wday_q == 8'h07) |=> (wday_o == 8'h01)); // R7

  AST_MONTH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    month_carry |=> (date_o == 8'h01)); // R8

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (year_carry && year_q == 8'h99) |=> (year_o == 8'h00)); // R9

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int SUBDIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  logic any_wr, adv, halt, sec_wr, day_carry;

  // Select code 7 is not a write, so it neither loads nor blocks a tick.
  assign any_wr = wr_en_i && (wr_sel_i != FLD_NONE);

  rtc_tick_gate #(.SUBDIV(SUBDIV)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .halt_i   (halt),
    .any_wr_i (any_wr),
    .sec_wr_i (sec_wr),
    .adv_o    (adv)
  );

  rtc_time_chain u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .sec_o       (sec_o),
    .min_o       (min_o),
    .hour_o      (hour_o),
    .halt_o      (halt),
    .sec_wr_o    (sec_wr),
    .day_carry_o (day_carry)
  );

  rtc_date_chain u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry_i (day_carry),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .date_o      (date_o),
    .month_o     (month_o),
    .wday_o      (wday_o),
    .year_o      (year_o)
  );

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                $stable(date_o) && $stable(wday_o))); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i != FLD_SEC && wr_sel_i != FLD_NONE) |=> $stable(sec_o)); // R10

  AST_SEL7_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == FLD_NONE && !tick_i) |=>
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(year_o))); // R1

endmodule

// File: tb/tb_rtc_bcd_core.sv
module tb_rtc_bcd_core;
  localparam int SUBDIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;

  always #10 clk = ~clk;

  rtc_bcd_core #(.SUBDIV(SUBDIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .wday_o(wday_o), .year_o(year_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R12";
  bit done = 1'b0;

  // Behavioural reference model: plain integers
  int m_sec, m_min, m_hr, m_date, m_mon, m_wday, m_year, m_sub;
  bit m_ch, m_h12, m_pm;

  function automatic logic [7:0] enc(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_new_day();
    m_wday = (m_wday >= 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date > days_in(m_mon, m_year)) begin
      m_date = 1;
      m_mon++;
      if (m_mon > 12) begin
        m_mon = 1;
        m_year = (m_year + 1) % 100;
      end
    end
  endtask

  task automatic model_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0;
    m_min++;
    if (m_min < 60) return;
    m_min = 0;
    if (m_h12) begin
      if (m_hr == 11) begin
        m_hr = 12;
        m_pm = !m_pm;
        if (!m_pm) model_new_day();
      end else if (m_hr == 12) m_hr = 1;
      else m_hr++;
    end else begin
      m_hr++;
      if (m_hr == 24) begin
        m_hr = 0;
        model_new_day();
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_date = 1; m_mon = 1; m_wday = 1;
      m_year = 0; m_sub = 0; m_ch = 0; m_h12 = 0; m_pm = 0;
    end else if (wr_en_i && wr_sel_i != 3'd7) begin
      case (wr_sel_i)
        3'd0: begin m_ch = wr_data_i[7]; m_sec = dec({1'b0, wr_data_i[6:0]}); m_sub = 0; end
        3'd1: m_min = dec({1'b0, wr_data_i[6:0]});
        3'd2: begin
          m_h12 = wr_data_i[7];
          if (m_h12) begin m_pm = wr_data_i[5]; m_hr = dec({3'b0, wr_data_i[4:0]}); end
          else begin m_pm = 0; m_hr = dec({2'b0, wr_data_i[5:0]}); end
        end
        3'd3: m_date = dec({2'b0, wr_data_i[5:0]});
        3'd4: m_mon  = dec({3'b0, wr_data_i[4:0]});
        3'd5: m_wday = int'(wr_data_i[2:0]);
        default: m_year = dec(wr_data_i);
      endcase
    end else if (tick_i && !m_ch) begin
      m_sub++;
      if (m_sub == SUBDIV) begin
        m_sub = 0;
        model_second();
      end
    end
  end

  task automatic cmp(input string f, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, f, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("sec",   sec_o,   {m_ch, enc(m_sec)[6:0]});
      cmp("min",   min_o,   enc(m_min));
      cmp("hour",  hour_o,  m_h12 ? {1'b1, 1'b0, m_pm, enc(m_hr)[4:0]} : enc(m_hr));
      cmp("date",  date_o,  enc(m_date));
      cmp("month", month_o, enc(m_mon));
      cmp("wday",  wday_o,  enc(m_wday));
      cmp("year",  year_o,  enc(m_year));
    end
  end

  // Stimulus helpers
  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic wr_tick(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; tick_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr, input logic [7:0] wd,
                         input logic [7:0] se);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd3, dt); wr(3'd4, mo);
    wr(3'd6, yr); wr(3'd5, wd); wr(3'd0, se);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R12"; repeat (2) @(negedge clk);

    cur_req = "R1";
    wr(3'd1, 8'hD5); wr(3'd3, 8'hE5); wr(3'd4, 8'hF1); wr(3'd5, 8'hFB);
    wr(3'd2, 8'hC5); wr(3'd6, 8'h42); wr(3'd7, 8'h33); repeat (2) @(negedge clk);

    cur_req = "R2";
    set_all(8'h10, 8'h20, 8'h05, 8'h06, 8'h21, 8'h02, 8'h57);
    ticks(3 * SUBDIV);

    cur_req = "R3";
    wr(3'd0, 8'hB0); ticks(2 * SUBDIV);
    wr(3'd0, 8'h30); ticks(SUBDIV);

    cur_req = "R4";
    set_all(8'h08, 8'h59, 8'h05, 8'h06, 8'h21, 8'h02, 8'h59);
    ticks(SUBDIV);

    cur_req = "R5";
    set_all(8'h23, 8'h59, 8'h14, 8'h03, 8'h21, 8'h04, 8'h58);
    ticks(2 * SUBDIV);

    cur_req = "R6";
    set_all(8'h91, 8'h59, 8'h10, 8'h07, 8'h22, 8'h03, 8'h59);
    ticks(SUBDIV);
    set_all(8'hB1, 8'h59, 8'h10, 8'h07, 8'h22, 8'h03, 8'h59);
    ticks(SUBDIV);
    set_all(8'hB2, 8'h59, 8'h10, 8'h07, 8'h22, 8'h03, 8'h59);
    ticks(SUBDIV);

    cur_req = "R7";
    set_all(8'h23, 8'h59, 8'h09, 8'h08, 8'h22, 8'h07, 8'h59);
    ticks(SUBDIV);

    cur_req = "R8";
    set_all(8'h23, 8'h59, 8'h29, 8'h02, 8'h24, 8'h01, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h28, 8'h02, 8'h23, 8'h01, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h28, 8'h02, 8'h24, 8'h01, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h30, 8'h04, 8'h23, 8'h01, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h30, 8'h01, 8'h23, 8'h01, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h31, 8'h01, 8'h23, 8'h01, 8'h59); ticks(SUBDIV);

    cur_req = "R9";
    set_all(8'h23, 8'h59, 8'h31, 8'h12, 8'h99, 8'h06, 8'h59); ticks(SUBDIV);
    set_all(8'h23, 8'h59, 8'h31, 8'h12, 8'h45, 8'h06, 8'h59); ticks(SUBDIV);

    cur_req = "R10";
    wr(3'd0, 8'h20); ticks(SUBDIV - 1);
    wr_tick(3'd1, 8'h07); ticks(1);
    ticks(SUBDIV - 1); wr_tick(3'd6, 8'h50); ticks(1);

    cur_req = "R11";
    wr(3'd0, 8'h10); ticks(SUBDIV - 1);
    wr_tick(3'd0, 8'h40); ticks(SUBDIV - 1); ticks(1);
    ticks(1); wr(3'd0, 8'h05); ticks(SUBDIV);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule